// File: doc/BRIEF.md
# Stream Segmenter With Boundary Flags

This block sits on an unbounded sample stream that arrives with a one-bit keep
qualifier per sample. It cuts the stream into finite segments. A segment is a
maximal run of consecutive samples whose keep bit is 1. Samples whose keep bit
is 0 are consumed and discarded. Each forwarded sample carries two flags:
`outBegin` marks the first sample of a segment and `outEnd` marks the last.
Downstream logic can use these flags to reset its state when a segment starts
and to flush or finalise when it finishes. Each segment is handled on its own.

Whether a kept sample is the last of its run is only known once the next input
arrives. For that reason the block holds one kept sample in a lookahead
register. It releases the held sample when the next sample is accepted, or
when the `flush` input asks it to close the open segment at once. Both sides
use valid/ready handshakes. A stalled output stalls the input, and no sample is
lost or repeated.

Top module: `stream_segmenter`

## Requirements
- R1: Samples with keep bit 1 are forwarded in arrival order, each exactly once. Samples with keep bit 0 never appear on the output.
- R2: `outBegin` is 1 on a forwarded sample exactly when the input sample accepted just before it had keep bit 0, or when it is the first kept sample after reset or after a closed segment.
- R3: `outEnd` is 1 on a forwarded sample when the next accepted input has keep bit 0, and 0 when the next accepted input has keep bit 1.
- R4: A segment of exactly one kept sample is emitted as a single beat with both `outBegin` and `outEnd` equal to 1.
- R5: While `flush` is 1, `inReady` is 0. A flush with a segment open emits the held sample with `outEnd` 1. A flush with no segment open emits nothing.
- R6: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData`, `outBegin` and `outEnd` hold their values on the next cycle.
- R7: A synchronous active-high `rst` clears the output register and any held sample. After reset `outValid` is 0, and a held sample is never emitted.
- R8: A kept sample stays hidden from the output until a later input is accepted or a flush occurs. A lone kept sample leaves `outValid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample valid |
| inData | input | DATA_W | Input sample value |
| inKeep | input | 1 | 1 = sample belongs to a segment, 0 = drop |
| inReady | output | 1 | Block accepts an input sample this cycle |
| flush | input | 1 | Close any open segment now |
| outValid | output | 1 | Output beat valid |
| outData | output | DATA_W | Output sample value |
| outBegin | output | 1 | Beat is the first sample of a segment |
| outEnd | output | 1 | Beat is the last sample of a segment |
| outReady | input | 1 | Downstream accepts the output beat |

## Verification
The framing assertions rely on two assumptions about the inputs. First, `outReady` is honoured as a normal handshake. Second, `flush` is a level that the environment raises only when it wants the segment closed. The bench changes all inputs one time unit after the rising edge, so handshakes resolve cleanly at the next edge. It raises `flush` only for single cycles, between sample transfers. Every stimulus stream ends with either a keep-0 sample or a flush, so no sample is left waiting in the lookahead register when the results are compared.

// File: rtl/seg_pkg.sv
package seg_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic loadBuf;    // capture inData into lookahead register
    logic emit;       // move held sample into the output register
    logic emitBegin;  // flag value for the emitted beat
    logic emitEnd;    // flag value for the emitted beat
  } segStrobes_t;
endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inKeep,
  input  logic        flush,
  input  logic        slotFree,
  output logic        inReady,
  output segStrobes_t strobes
);

  logic bufValid;
  logic bufFirst;
  logic accept;

  assign inReady = slotFree && !flush;
  assign accept  = inValid && inReady;

  always_comb begin
    strobes.loadBuf   = accept && inKeep;
    strobes.emit      = bufValid && (accept || (flush && slotFree));
    strobes.emitEnd   = flush || !inKeep;
    strobes.emitBegin = bufFirst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufValid <= 1'b0;
      bufFirst <= 1'b0;
    end else if (strobes.loadBuf) begin
      bufValid <= 1'b1;
      bufFirst <= !bufValid;
    end else if (strobes.emit && strobes.emitEnd) begin
      bufValid <= 1'b0;
    end
  end

  // R5: a flush honoured with a held sample leaves the lookahead empty
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (rst)
    (flush && slotFree && bufValid) |=> !bufValid);

  // R8: an input of keep 1 onto an empty lookahead produces no emission
  a_r8_first_held: assert property (@(posedge clk) disable iff (rst)
    (accept && inKeep && !bufValid) |-> !strobes.emit);

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  segStrobes_t       strobes,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  output logic              slotFree,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outBegin,
  output logic              outEnd
);

  logic [DATA_W-1:0] bufData;

  assign slotFree = !outValid || outReady;

  always_ff @(posedge clk) begin
    if (strobes.loadBuf) bufData <= inData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
      outBegin <= 1'b0;
      outEnd   <= 1'b0;
    end else if (slotFree) begin
      outValid <= strobes.emit;
      if (strobes.emit) begin
        outData  <= bufData;
        outBegin <= strobes.emitBegin;
        outEnd   <= strobes.emitEnd;
      end
    end
  end

  // Framing monitor for assertions: inside a segment on the output side
  logic inSeg;
  always_ff @(posedge clk) begin
    if (rst) inSeg <= 1'b0;
    else if (outValid && outReady) inSeg <= !outEnd;
  end

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)
                                 && $stable(outBegin) && $stable(outEnd)));

  a_r2_begin_outside: assert property (@(posedge clk) disable iff (rst)
    (outValid && outBegin) |-> !inSeg);

  a_r3_cont_inside: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outBegin) |-> inSeg);

  a_r7_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> !outValid);

endmodule

// File: rtl/stream_segmenter.sv
module stream_segmenter
  import seg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inKeep,
  output logic              inReady,
  input  logic              flush,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outBegin,
  output logic              outEnd,
  input  logic              outReady
);

  segStrobes_t strobes;
  logic        slotFree;

  seg_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inKeep   (inKeep),
    .flush    (flush),
    .slotFree (slotFree),
    .inReady  (inReady),
    .strobes  (strobes)
  );

  seg_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inData   (inData),
    .outReady (outReady),
    .slotFree (slotFree),
    .outValid (outValid),
    .outData  (outData),
    .outBegin (outBegin),
    .outEnd   (outEnd)
  );

endmodule

// File: tb/tb_stream_segmenter.sv
`timescale 1ns/1ps
module tb_stream_segmenter;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inKeep = 1'b0;
  logic          inReady;
  logic          flush = 1'b0;
  logic          outValid;
  logic [DW-1:0] outData;
  logic          outBegin;
  logic          outEnd;
  logic          outReady;

  always #2.5 clk = ~clk;

  stream_segmenter #(.DATA_W(DW)) dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Output readiness: always 1 unless backpressure is enabled
  bit         bpEnable = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  initial outReady = 1'b1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = bpEnable ? lfsr[0] : 1'b1;
  end

  // Captured output beats
  logic [DW-1:0] gotData[64];
  logic          gotBeg[64];
  logic          gotEnd[64];
  int            gotN = 0;
  logic [DW-1:0] expData[64];
  logic          expBeg[64];
  logic          expEnd[64];
  int            expN = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor at negedge; also checks hold under stall (R6)
  bit            held = 1'b0;
  logic [DW-1:0] hData;
  logic          hBeg, hEnd;
  always @(negedge clk) begin
    if (!rst) begin
      if (held) begin
        check(outValid && outData == hData && outBegin == hBeg && outEnd == hEnd,
              "R6", "stalled beat changed", int'(outData), int'(hData));
      end
      held = outValid && !outReady;
      hData = outData; hBeg = outBegin; hEnd = outEnd;
      if (outValid && outReady && gotN < 64) begin
        gotData[gotN] = outData; gotBeg[gotN] = outBegin; gotEnd[gotN] = outEnd;
        gotN++;
      end
    end else held = 1'b0;
  end

  task automatic sendOne(input logic [DW-1:0] d, input logic k);
    bit acc;
    inValid = 1'b1; inData = d; inKeep = k;
    forever begin
      @(negedge clk); acc = inReady;
      @(posedge clk); #1;
      if (acc) break;
    end
    inValid = 1'b0;
  endtask

  task automatic pulseFlush(input string req);
    flush = 1'b1;
    @(negedge clk);
    check(inReady == 1'b0, req, "inReady during flush", int'(inReady), 0);
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // Drive a stream, build expectation from the rules, compare
  task automatic runStream(input logic [DW-1:0] base, input logic keeps[],
                           input bit closeFlush, input string req);
    int n = keeps.size();
    gotN = 0; expN = 0;
    for (int i = 0; i < n; i++) begin
      if (keeps[i]) begin
        expData[expN] = base + DW'(i);
        expBeg[expN]  = (i == 0) || !keeps[i-1];
        expEnd[expN]  = (i == n-1) ? closeFlush : !keeps[i+1];
        expN++;
      end
    end
    for (int i = 0; i < n; i++) sendOne(base + DW'(i), keeps[i]);
    if (closeFlush) pulseFlush("R5");
    bpEnable = 1'b0;
    idle(10);
    check(gotN == expN, req, "beat count", gotN, expN);
    for (int j = 0; j < expN && j < gotN; j++) begin
      check(gotData[j] == expData[j], req, "data", int'(gotData[j]), int'(expData[j]));
      check(gotBeg[j] == expBeg[j], req, "begin flag", int'(gotBeg[j]), int'(expBeg[j]));
      check(gotEnd[j] == expEnd[j], req, "end flag", int'(gotEnd[j]), int'(expEnd[j]));
    end
  endtask

  task automatic doReset();
    rst = 1'b1; idle(2); rst = 1'b0; #0;
  endtask

  task automatic tResetState();
    doReset();
    @(negedge clk);
    check(outValid == 1'b0, "R7", "outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R7", "inReady after reset", int'(inReady), 1);
    @(posedge clk); #1;
  endtask

  task automatic tExample();  // R1 R2 R3: 0,1,1,0,1,1,1,0
    runStream(16'h0A00, '{0,1,1,0,1,1,1,0}, 1'b0, "R1/R2/R3");
    check(gotN == 5, "R1", "kept samples", gotN, 5);
  endtask

  task automatic tSingles();  // R4
    runStream(16'h0B00, '{1,0,1,0,0,1,0}, 1'b0, "R4");
    for (int j = 0; j < gotN; j++)
      check(gotBeg[j] && gotEnd[j], "R4", "single-beat flags",
            int'({gotBeg[j], gotEnd[j]}), 3);
  endtask

  task automatic tBackpressure();  // R6 R1
    bpEnable = 1'b1;
    runStream(16'h0C00, '{1,1,1,0,1,1,0,0,1,1,1,1,0,1,0}, 1'b0, "R6");
  endtask

  task automatic tFlush();  // R5
    runStream(16'h0D00, '{0,1,1}, 1'b1, "R5");
    gotN = 0;
    pulseFlush("R5");
    idle(5);
    check(gotN == 0, "R5", "flush with no open segment", gotN, 0);
  endtask

  task automatic tLookahead();  // R8
    gotN = 0;
    sendOne(16'h0E01, 1'b1);
    idle(5);
    @(negedge clk);
    check(outValid == 1'b0, "R8", "lone kept sample hidden", int'(outValid), 0);
    @(posedge clk); #1;
    pulseFlush("R5");
    idle(3);
    check(gotN == 1 && gotData[0] == 16'h0E01 && gotBeg[0] && gotEnd[0], "R8",
          "released on flush", gotN, 1);
  endtask

  task automatic tResetMid();  // R7
    sendOne(16'h0F01, 1'b1);
    doReset();
    gotN = 0;
    sendOne(16'h0F02, 1'b0);
    idle(5);
    check(gotN == 0, "R7", "held sample dropped by reset", gotN, 0);
    runStream(16'h0F10, '{1,0}, 1'b0, "R7");
  endtask

  initial begin
    tResetState();
    tExample();
    tSingles();
    tBackpressure();
    tFlush();
    tLookahead();
    tResetMid();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule